// File: doc/BRIEF.md
# Hierarchical Lookahead Adder (16-bit)

This block adds two 16-bit unsigned or two's-complement operands and a carry-in. The operands are split into four 4-bit slices. Each slice forms a generate and a propagate signal for every bit. From these it derives all of its internal carries as flat sum-of-products terms and its own group generate and group propagate. A second-level carry network applies the same equations to the four slice group pairs and the adder carry-in, so the carry into every slice is known without rippling through the slices below it.

The whole adder also reports its own group propagate and group generate, so a third lookahead level can place several of these adders side by side. The sum, carry-out and group pair are captured in one output register stage. All results appear on the ports one clock after the operands are sampled. The combinational depth from any operand bit to any sum bit is fixed and does not grow with the length of a carry chain.

Top module: `cla16_adder`

## Requirements
- R1: For each bit i, the generate is a[i] AND b[i] and the propagate is a[i] XOR b[i]; sum bit i is the propagate XOR the carry into bit i, so adding zero with no carry-in returns the other operand unchanged.
- R2: Inside a slice, the carry into each bit is the OR of that bit's lower generates, each ANDed with every propagate between it and the bit, plus the slice carry-in ANDed with all lower propagates; it always equals the one-step relation c[i+1] = g[i] OR (p[i] AND c[i]).
- R3: A slice's group propagate is the AND of its four propagates, its group generate is g3 + p3g2 + p3p2g1 + p3p2p1g0, and its own carry-out equals group generate OR (group propagate AND slice carry-in).
- R4: The second-level network computes the carries into slices 1, 2 and 3 and the final carry from the slice group pairs and the adder carry-in alone; each of these matches the carry-out that the slice below would produce.
- R5: One clock after the operands are sampled, {cout_o, sum_o} equals a_i + b_i + cin_i as a 17-bit unsigned sum.
- R6: grp_p_o is 1 exactly when every bit of a_i XOR b_i is 1; grp_g_o is the carry-out of a_i + b_i with carry-in 0; cout_o equals grp_g_o OR (grp_p_o AND the sampled cin_i).
- R7: While rst_n is low, sum_o, cout_o, grp_p_o and grp_g_o are all 0.
- R8: Operand pairs whose carry runs through every bit (0xFFFF + 0x0001, 0xFFFF + 0x0000 with carry-in 1) give sum 0x0000 and carry-out 1, with the full carry produced in the same single cycle as any other sum.
- R9: grp_p_o and grp_g_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; results are registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Registered sum |
| cout_o | output | 1 | Registered carry out of bit 15 |
| grp_p_o | output | 1 | Registered group propagate of all 16 bits |
| grp_g_o | output | 1 | Registered group generate of all 16 bits |

## Verification
The lookahead network has no internal state, so every output (sum, carry-out, group propagate and group generate) is due exactly one rising edge after the operands are applied. The bench changes the operands on a falling edge, waits for the next rising edge, and samples all four outputs on the falling edge after it. This places each comparison half a period clear of both the capturing edge and the next operand change. The embedded properties reach back by the same single cycle through $past, and a flag keeps them quiet until one clean edge has followed reset.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Default geometry of the adder.
    parameter int unsigned SLICE_W_DEF    = 4;
    parameter int unsigned NUM_SLICES_DEF = 4;

    // Group propagate / generate pair produced by any lookahead level.
    typedef struct packed {
        logic p;
        logic g;
    } grp_pg_t;

endpackage

// File: rtl/cla_carry_net.sv
// Flat sum-of-products lookahead over N generate/propagate pairs.
// Used both inside a slice (per bit) and as the second level (per slice).
module cla_carry_net #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    input  logic         cin_i,
    output logic [N:0]   c_o,
    output logic         grp_p_o,
    output logic         grp_g_o
);

    assign c_o[0] = cin_i;

    // Carry into position i: every term is a single AND of inputs, then one OR.
    for (genvar i = 1; i <= N; i++) begin : g_carry
        logic [i:0] terms;
        assign terms[0] = cin_i & (&p_i[i-1:0]);
        for (genvar j = 1; j <= i; j++) begin : g_term
            if (j == i) begin : g_last
                assign terms[j] = g_i[i-1];
            end else begin : g_mid
                assign terms[j] = g_i[j-1] & (&p_i[i-1:j]);
            end
        end
        assign c_o[i] = |terms;
    end

    // Group generate: same expansion with the carry-in term left out.
    logic [N-1:0] gg_terms;
    for (genvar j = 0; j < N; j++) begin : g_grp
        if (j == N - 1) begin : g_top
            assign gg_terms[j] = g_i[j];
        end else begin : g_low
            assign gg_terms[j] = g_i[j] & (&p_i[N-1:j+1]);
        end
    end

    assign grp_g_o = |gg_terms;
    assign grp_p_o = &p_i;

    // The flat terms must agree with the one-step carry relation.
    always_comb begin
        for (int k = 0; k < N; k++) begin
            if (!$isunknown({g_i, p_i, cin_i})) begin
                AST_CARRY_STEP: assert (c_o[k+1] == (g_i[k] | (p_i[k] & c_o[k]))); // R2
            end
        end
    end

endmodule

// File: rtl/cla_slice.sv
// One lookahead slice: per-bit generate/propagate, internal carries, sum, group pair.
module cla_slice
    import cla_pkg::*;
#(
    parameter int unsigned SLICE_W = SLICE_W_DEF
) (
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    input  logic               cin_i,
    output logic [SLICE_W-1:0] sum_o,
    output logic               cout_o,
    output grp_pg_t            grp_o
);

    logic [SLICE_W-1:0] bit_g;
    logic [SLICE_W-1:0] bit_p;
    logic [SLICE_W:0]   bit_c;
    logic               sl_p;
    logic               sl_g;

    // Per-bit generate and propagate.
    for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        assign bit_g[i] = a_i[i] & b_i[i];
        assign bit_p[i] = a_i[i] ^ b_i[i];
        assign sum_o[i] = bit_p[i] ^ bit_c[i];
    end

    cla_carry_net #(
        .N (SLICE_W)
    ) carry_net_i (
        .g_i     (bit_g),
        .p_i     (bit_p),
        .cin_i   (cin_i),
        .c_o     (bit_c),
        .grp_p_o (sl_p),
        .grp_g_o (sl_g)
    );

    assign cout_o = bit_c[SLICE_W];
    assign grp_o  = '{p: sl_p, g: sl_g};

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            AST_SLICE_GROUP_COUT: assert (cout_o == (sl_g | (sl_p & cin_i))); // R3
            AST_SLICE_PG_EXCL: assert (!(sl_g && sl_p)); // R9
        end
    end

endmodule

// File: rtl/cla16_adder.sv
// Two-level lookahead adder with a registered result stage.
module cla16_adder
    import cla_pkg::*;
#(
    parameter int unsigned SLICE_W    = SLICE_W_DEF,
    parameter int unsigned NUM_SLICES = NUM_SLICES_DEF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [SLICE_W*NUM_SLICES-1:0]   a_i,
    input  logic [SLICE_W*NUM_SLICES-1:0]   b_i,
    input  logic                            cin_i,
    output logic [SLICE_W*NUM_SLICES-1:0]   sum_o,
    output logic                            cout_o,
    output logic                            grp_p_o,
    output logic                            grp_g_o
);

    localparam int unsigned DATA_W = SLICE_W * NUM_SLICES;

    typedef struct packed {
        logic [DATA_W-1:0] sum;
        logic              cout;
        logic              gp;
        logic              gg;
    } res_t;

    logic [NUM_SLICES-1:0] sl_p;
    logic [NUM_SLICES-1:0] sl_g;
    logic [NUM_SLICES-1:0] sl_cout;
    logic [NUM_SLICES:0]   sl_c;
    logic [DATA_W-1:0]     sum_w;
    logic                  top_p;
    logic                  top_g;

    // First level: the slices.
    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        grp_pg_t pg;
        cla_slice #(
            .SLICE_W (SLICE_W)
        ) slice_i (
            .a_i    (a_i[k*SLICE_W +: SLICE_W]),
            .b_i    (b_i[k*SLICE_W +: SLICE_W]),
            .cin_i  (sl_c[k]),
            .sum_o  (sum_w[k*SLICE_W +: SLICE_W]),
            .cout_o (sl_cout[k]),
            .grp_o  (pg)
        );
        assign sl_p[k] = pg.p;
        assign sl_g[k] = pg.g;
    end

    // Second level: slice carries from slice group pairs and the adder carry-in.
    cla_carry_net #(
        .N (NUM_SLICES)
    ) upper_net_i (
        .g_i     (sl_g),
        .p_i     (sl_p),
        .cin_i   (cin_i),
        .c_o     (sl_c),
        .grp_p_o (top_p),
        .grp_g_o (top_g)
    );

    res_t res_d;
    res_t res_q;
    logic past_ok_d;
    logic past_ok_q;

    always_comb begin
        res_d.sum  = sum_w;
        res_d.cout = sl_c[NUM_SLICES];
        res_d.gp   = top_p;
        res_d.gg   = top_g;
        past_ok_d  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q     <= '0;
            past_ok_q <= 1'b0;
        end else begin
            res_q     <= res_d;
            past_ok_q <= past_ok_d;
        end
    end

    assign sum_o   = res_q.sum;
    assign cout_o  = res_q.cout;
    assign grp_p_o = res_q.gp;
    assign grp_g_o = res_q.gg;

    AST_SLICE_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        sl_cout == sl_c[NUM_SLICES:1]); // R4

    AST_RESULT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> ({res_q.cout, res_q.sum} ==
                       $past({1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i}))); // R5

    AST_COUT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (res_q.cout == (res_q.gg | (res_q.gp & $past(cin_i))))); // R6

    AST_GRP_PROP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (res_q.gp == (&$past(a_i ^ b_i)))); // R6

    AST_PG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_q.gp && res_q.gg)); // R9

endmodule

// File: tb/cla16_adder_tb.sv
module cla16_adder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout;
    logic        gp;
    logic        gg;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cla16_adder dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_i     (a),
        .b_i     (b),
        .cin_i   (cin),
        .sum_o   (sum),
        .cout_o  (cout),
        .grp_p_o (gp),
        .grp_g_o (gg)
    );

    function automatic logic [16:0] ref_total(logic [15:0] x, logic [15:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {16'd0, c};
    endfunction

    function automatic logic ref_gp(logic [15:0] x, logic [15:0] y);
        return &(x ^ y);
    endfunction

    function automatic logic ref_gg(logic [15:0] x, logic [15:0] y);
        logic [16:0] t;
        t = {1'b0, x} + {1'b0, y};
        return t[16];
    endfunction

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    // Apply on a falling edge, registered on the next rising edge, sampled one falling edge later.
    task automatic apply(string req, logic [15:0] x, logic [15:0] y, logic c);
        logic [16:0] t;
        @(negedge clk);
        a = x; b = y; cin = c;
        @(posedge clk);
        @(negedge clk);
        t = ref_total(x, y, c);
        chk(req, "sum",  {16'd0, sum}, {16'd0, t[15:0]});
        chk(req, "cout", {31'd0, cout}, {31'd0, t[16]});
        chk(req, "grp_p", {31'd0, gp}, {31'd0, ref_gp(x, y)});
        chk(req, "grp_g", {31'd0, gg}, {31'd0, ref_gg(x, y)});
        chk("R9", "pg_excl", {31'd0, gp & gg}, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        a = 16'hFFFF; b = 16'hFFFF; cin = 1'b1;
        repeat (3) @(negedge clk);
        // R7: outputs stay at zero while reset is held, whatever the operands.
        chk("R7", "sum_rst",  {16'd0, sum}, 32'd0);
        chk("R7", "cout_rst", {31'd0, cout}, 32'd0);
        chk("R7", "gp_rst",   {31'd0, gp}, 32'd0);
        chk("R7", "gg_rst",   {31'd0, gg}, 32'd0);
        rst_n = 1'b1;

        apply("R1", 16'h1234, 16'h0000, 1'b0);
        apply("R1", 16'h0000, 16'hBEEF, 1'b0);
        apply("R5", 16'h0000, 16'h0000, 1'b0);
        apply("R8", 16'hFFFF, 16'h0001, 1'b0);
        apply("R8", 16'hFFFF, 16'h0000, 1'b1);
        apply("R6", 16'hFFFF, 16'hFFFF, 1'b1);
        apply("R6", 16'hAAAA, 16'h5555, 1'b0);
        apply("R6", 16'hAAAA, 16'h5555, 1'b1);
        apply("R6", 16'h8000, 16'h8000, 1'b0);
        apply("R2", 16'h0007, 16'h0001, 1'b0);
        apply("R2", 16'h0003, 16'h0000, 1'b1);
        apply("R3", 16'h000F, 16'h0000, 1'b1);
        apply("R3", 16'h00F0, 16'h0010, 1'b0);
        apply("R4", 16'h000F, 16'h0001, 1'b0);
        apply("R4", 16'h00FF, 16'h0001, 1'b0);
        apply("R4", 16'h0FFF, 16'h0000, 1'b1);
        apply("R4", 16'h0F0F, 16'h00F1, 1'b0);

        // R5: random operands, with a bias toward long carry runs.
        for (int n = 0; n < 400; n++) begin
            logic [15:0] x;
            logic [15:0] y;
            x = 16'($urandom);
            y = 16'($urandom);
            if (n % 4 == 0) y = ~x ^ (16'd1 << ($urandom % 16));
            if (n % 4 == 1) y = ~x;
            apply("R5", x, y, 1'($urandom));
        end

        // R7: asserting reset again clears a non-zero result.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R7", "sum_rerst",  {16'd0, sum}, 32'd0);
        chk("R7", "cout_rerst", {31'd0, cout}, 32'd0);
        finish_run();
    end

endmodule